// File: doc/BRIEF.md
# Loop-bound vector predicate generator

This block turns two scalar operands, a start counter and a limit, into a lane-enable predicate for a vector unit. Element `e` is given the counter value `start + e` and compares it, unsigned, against the limit. The comparison is either strict less-than or less-than-or-equal. Elements are active from element 0 up to the first element whose comparison fails. That element and every element above it are inactive, even when a later counter value would pass again.

The predicate has one bit per vector byte. Each element's bit sits in the lowest byte position of that element's slot. The block also returns the four condition flags of the result. The vector length is a parameter. A result is accepted with `in_valid` and presented one clock later with `out_valid`. A vector loop controller uses the predicate to switch off the tail lanes of the final iteration. It uses the flags to decide whether to branch back.

Top module: `lane_bound_pred`

## Requirements
- R1: Element `e` uses the counter `start_val + e`. The sum is formed at the selected operand width and wraps modulo 2^width. One is added per element, whatever the element size.
- R2: Once an element's comparison fails, that element and every higher-numbered element are inactive, including elements whose wrapped counter would pass.
- R3: All comparisons are unsigned. `op_le`=1 selects counter <= limit. `op_le`=0 selects counter < limit.
- R4: `wide64`=1 compares all 64 operand bits. `wide64`=0 uses only bits [31:0] of both operands, and bits [63:32] have no effect on the result.
- R5: With `op_le`=1 and a limit equal to the largest unsigned value of the selected width, every element is active.
- R6: `esz` encodes the element size: 0 is byte, 1 is halfword, 2 is word, 3 is doubleword. There are VL/(8·2^esz) elements. Element `e`'s bit is `pred[e·2^esz]`, and every other predicate bit is 0.
- R7: `flags` is {N,Z,C,V} in bits [3:0]. N is `pred[0]`. Z is 1 when no element is active. C is the inverse of the last element's bit. V is 0.
- R8: With `op_le`=0 and a start not below the limit, the predicate is all zero and the flags are N=0, Z=1, C=1, V=0.
- R9: `out_valid` rises exactly one clock after a cycle with `in_valid`=1. `pred` and `flags` are updated only by such cycles and hold their values otherwise.
- R10: While `rst_n` is low, `out_valid`, `pred` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| start_val | input | 64 | Start counter operand |
| limit_val | input | 64 | Limit operand |
| wide64 | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| esz | input | 2 | Element size code |
| op_le | input | 1 | 1: lower-or-same, 0: lower-than |
| out_valid | output | 1 | Result valid |
| pred | output | VL_BITS/8 | Byte-granular predicate |
| flags | output | 4 | {N,Z,C,V} |

## Verification
There is no state between operations, so any wrong internal value shows up at the ports on the cycle `out_valid` is asserted. A faulty lane comparator or counter bit shows up as a predicate bit in the wrong position. A broken sticky chain shows up as a 1 above a 0, which is easiest to see with wrapped counters. A wrong slot layout or a wrong last-element index shows up as a misplaced bit or a wrong C flag, so every element size is exercised.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  localparam int OPW = 64;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/lbp_lane_cmp.sv
module lbp_lane_cmp #(
  parameter int LANES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [lbp_pkg::OPW-1:0] start_val,
  input  logic [lbp_pkg::OPW-1:0] limit_val,
  input  logic                   wide64,
  input  logic                   op_le,
  output logic [LANES-1:0]       act
);
  localparam int W = lbp_pkg::OPW;

  logic [LANES-1:0] pass;
  logic [W-1:0]     lim_eff;

  assign lim_eff = wide64 ? limit_val : {32'd0, limit_val[31:0]};

  // one counter and comparator per byte lane; shared by all element sizes
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [W-1:0] sum;
    logic [W-1:0] cnt;
    assign sum = start_val + W'(e);
    assign cnt = wide64 ? sum : {32'd0, sum[31:0]};
    assign pass[e] = op_le ? (cnt <= lim_eff) : (cnt < lim_eff);
  end

  // sticky running enable
  always_comb begin
    logic run;
    run = 1'b1;
    for (int e = 0; e < LANES; e++) begin
      run    = run & pass[e];
      act[e] = run;
    end
  end

  // R2: active lanes form a contiguous run from lane 0
  a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((act & (act + LANES'(1))) == '0));
endmodule

// File: rtl/lbp_pred_pack.sv
module lbp_pred_pack #(
  parameter int PRED_W = 32
) (
  input  logic [PRED_W-1:0] act,
  input  logic [1:0]        esz,
  output logic [PRED_W-1:0] pred
);
  for (genvar s = 0; s < 4; s++) begin : g_sz
    logic [PRED_W-1:0] lay;
    always_comb begin
      lay = '0;
      for (int e = 0; e < (PRED_W >> s); e++) begin
        lay[e << s] = act[e];
      end
    end
  end

  always_comb begin
    case (lbp_pkg::esz_e'(esz))
      lbp_pkg::ESZ_B: pred = g_sz[0].lay;
      lbp_pkg::ESZ_H: pred = g_sz[1].lay;
      lbp_pkg::ESZ_W: pred = g_sz[2].lay;
      default:        pred = g_sz[3].lay;
    endcase
  end
endmodule

// File: rtl/lbp_flag_gen.sv
module lbp_flag_gen #(
  parameter int PRED_W = 32
) (
  input  logic [PRED_W-1:0]   pred,
  input  logic [1:0]          esz,
  output lbp_pkg::nzcv_t      flags
);
  localparam int IW = $clog2(PRED_W);

  logic [IW-1:0] last_pos;

  assign last_pos = IW'(PRED_W - (32'd1 << esz));

  always_comb begin
    flags.n = pred[0];
    flags.z = ~|pred;
    flags.c = ~pred[last_pos];
    flags.v = 1'b0;
  end
endmodule

// File: rtl/lane_bound_pred.sv
module lane_bound_pred #(
  parameter int VL_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [63:0]           start_val,
  input  logic [63:0]           limit_val,
  input  logic                  wide64,
  input  logic [1:0]            esz,
  input  logic                  op_le,
  output logic                  out_valid,
  output logic [VL_BITS/8-1:0]  pred,
  output logic [3:0]            flags
);
  localparam int PRED_W = VL_BITS / 8;

  logic [PRED_W-1:0] act;
  logic [PRED_W-1:0] pred_d;
  lbp_pkg::nzcv_t    flags_d;
  logic [PRED_W-1:0] pred_q;
  logic [3:0]        flags_q;
  logic              vld_q;
  logic [PRED_W-1:0] pred_nx;
  logic [3:0]        flags_nx;

  lbp_lane_cmp #(.LANES(PRED_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .start_val(start_val), .limit_val(limit_val),
    .wide64(wide64), .op_le(op_le), .act(act)
  );

  lbp_pred_pack #(.PRED_W(PRED_W)) u_pack (
    .act(act), .esz(esz), .pred(pred_d)
  );

  lbp_flag_gen #(.PRED_W(PRED_W)) u_flags (
    .pred(pred_d), .esz(esz), .flags(flags_d)
  );

  // next state with explicit capture enable
  always_comb begin
    pred_nx  = pred_q;
    flags_nx = flags_q;
    if (in_valid) begin
      pred_nx  = pred_d;
      flags_nx = flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      pred_q  <= '0;
      flags_q <= '0;
    end else begin
      vld_q   <= in_valid;
      pred_q  <= pred_nx;
      flags_q <= flags_nx;
    end
  end

  assign out_valid = vld_q;
  assign pred      = pred_q;
  assign flags     = flags_q;

  function automatic logic [PRED_W-1:0] slot_mask(input logic [1:0] sz);
    logic [PRED_W-1:0] m;
    m = '0;
    for (int e = 0; e < PRED_W; e++) begin
      if ((e % (1 << sz)) == 0) m[e] = 1'b1;
    end
    return m;
  endfunction

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(pred) && $stable(flags)));
  a_r6_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((pred & ~slot_mask($past(esz))) == '0));
  a_r7_flag_rel: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[3] == pred[0] && flags[2] == (pred == '0) && !flags[0]));
  a_r5_all_true: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_le && (wide64 ? (&limit_val) : (&limit_val[31:0])))
      |=> (pred[0] && flags[2:1] == 2'b00));
  a_r8_dead_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_le &&
     (wide64 ? (start_val >= limit_val) : (start_val[31:0] >= limit_val[31:0])))
      |=> (pred == '0 && flags == 4'b0110));
endmodule

// File: tb/lane_bound_pred_test.sv
`timescale 1ns/1ps
module lane_bound_pred_test;
  localparam int VL = 256;
  localparam int PW = VL / 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [63:0]   start_val;
  logic [63:0]   limit_val;
  logic          wide64;
  logic [1:0]    esz;
  logic          op_le;
  logic          out_valid;
  logic [PW-1:0] pred;
  logic [3:0]    flags;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  lane_bound_pred #(.VL_BITS(VL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .start_val(start_val), .limit_val(limit_val),
    .wide64(wide64), .esz(esz), .op_le(op_le),
    .out_valid(out_valid), .pred(pred), .flags(flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [PW-1:0] exp_pred(input logic [63:0] s, input logic [63:0] l,
                                             input logic w, input logic [1:0] z, input logic le);
    logic [PW-1:0] r;
    logic [63:0] c;
    logic [63:0] lim;
    logic run;
    r = '0;
    run = 1'b1;
    lim = w ? l : {32'd0, l[31:0]};
    for (int e = 0; e < (PW >> z); e++) begin
      c = s + 64'(e);
      if (!w) c = {32'd0, c[31:0]};
      run = run && (le ? (c <= lim) : (c < lim));
      r[e << z] = run;
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_flags(input logic [PW-1:0] p, input logic [1:0] z);
    return {p[0], (p == '0), ~p[PW - (1 << z)], 1'b0};
  endfunction

  task automatic check(input string req, input logic [PW-1:0] ap, input logic [3:0] af,
                       input logic av, input logic [PW-1:0] ep, input logic [3:0] ef,
                       input logic ev);
    n_tests = n_tests + 1;
    if (ap !== ep || af !== ef || av !== ev) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual pred=%h flags=%b vld=%b expected pred=%h flags=%b vld=%b",
               req, ap, af, av, ep, ef, ev);
    end
  endtask

  task automatic apply(input string req, input logic [63:0] s, input logic [63:0] l,
                       input logic w, input logic [1:0] z, input logic le);
    logic [PW-1:0] ep;
    @(negedge clk);
    start_val = s; limit_val = l; wide64 = w; esz = z; op_le = le; in_valid = 1'b1;
    ep = exp_pred(s, l, w, z, le);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, pred, flags, out_valid, ep, exp_flags(ep, z), 1'b1);
  endtask

  initial begin
    logic [PW-1:0] held_p;
    logic [3:0]    held_f;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; start_val = '0; limit_val = '0;
    wide64 = 1'b1; esz = 2'd0; op_le = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", pred, flags, out_valid, '0, 4'b0000, 1'b0);
    rst_n = 1'b1;

    // R1/R3 partial runs, each element size (R6, R7)
    apply("R1", 64'd100, 64'd110, 1'b1, 2'd0, 1'b0);
    apply("R3", 64'd100, 64'd110, 1'b1, 2'd0, 1'b1);
    apply("R6", 64'd5, 64'd9, 1'b1, 2'd1, 1'b1);
    apply("R6", 64'd5, 64'd9, 1'b1, 2'd2, 1'b0);
    apply("R7", 64'd0, 64'd3, 1'b1, 2'd3, 1'b1);
    apply("R7", 64'd0, 64'd2, 1'b1, 2'd3, 1'b1);
    // R3 unsigned: large start vs small limit
    apply("R3", 64'h8000_0000_0000_0000, 64'd7, 1'b1, 2'd0, 1'b1);
    // R5 maximum limit, both widths
    apply("R5", 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd0, 1'b1);
    apply("R5", 64'h0000_0000_FFFF_FFF8, 64'h0000_0000_FFFF_FFFF, 1'b0, 2'd0, 1'b1);
    // R2 wrap cannot reactivate lanes
    apply("R2", 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_FFFF_FFFF, 1'b0, 2'd0, 1'b0);
    apply("R2", 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd0, 1'b0);
    // R4 upper bits ignored in 32-bit mode
    apply("R4", 64'hDEAD_BEEF_0000_0010, 64'h0123_4567_0000_0018, 1'b0, 2'd0, 1'b0);
    apply("R4", 64'h0000_0001_0000_0010, 64'h0000_0000_0000_0018, 1'b0, 2'd0, 1'b1);
    apply("R4", 64'h0000_0001_0000_0010, 64'h0000_0000_0000_0018, 1'b1, 2'd0, 1'b1);
    // R8 lower-than with a dead start
    apply("R8", 64'd50, 64'd50, 1'b1, 2'd1, 1'b0);
    apply("R8", 64'd0, 64'd0, 1'b0, 2'd2, 1'b0);

    // R9 outputs hold while idle
    apply("R9", 64'd1, 64'd4, 1'b1, 2'd0, 1'b1);
    held_p = pred; held_f = flags;
    @(negedge clk);
    start_val = 64'd999; limit_val = 64'd0; esz = 2'd3; in_valid = 1'b0;
    @(negedge clk);
    check("R9", pred, flags, out_valid, held_p, held_f, 1'b0);

    // random mix near the boundary
    for (int i = 0; i < 400; i++) begin
      logic [63:0] s;
      logic [63:0] l;
      logic w;
      s = {$urandom, $urandom};
      w = $urandom % 2;
      if ($urandom % 4 == 0) s[31:5] = '1;
      l = s + 64'($urandom % 48) - 64'd4;
      if ($urandom % 5 == 0) l = {$urandom, $urandom};
      if ($urandom % 8 == 0) s[63:32] = $urandom;
      apply("R1", s, l, w, 2'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule